// File: doc/BRIEF.md
# DMA Channel Event Combiner

This block sits between the per-channel status flags of a multi-channel DMA engine and the logic that services channel events. On a snapshot strobe it captures three flag vectors: completion, error and error type. From them it works out which channels ended with a real error and which completed normally. The captured flags are then released back to their sources through one-cycle clear pulses, so events that arrive later are kept for the next snapshot.

The classified events go into a pending word. Error events sit above completion events in that word. The events are presented one at a time on a valid/ready port, highest pending bit first, so every error is served before any completion. Each accepted event leaves the pending word. When an error event is accepted, the block pulses a soft-reset request for that channel.

Two states drive the block. In S_IDLE, a snapshot strobe captures the inputs. The transition SNAP_HIT goes to S_SERVE when at least one event was found. The transition SNAP_EMPTY stays in S_IDLE when nothing was found. In S_SERVE, an accepted event that is not the last one takes the transition SERVE_NEXT and stays in S_SERVE. Accepting the last event takes the transition SERVE_LAST back to S_IDLE.

Top module: `dma_evt_combiner`

## Requirements
- R1: After reset, evt_valid_o is 0, and done_clr_o, err_clr_o and chan_rst_o are all zero.
- R2: A channel whose error flag and error-type bit are both set is reported as an error event (evt_is_err_o = 1), whatever its completion flag.
- R3: A channel whose error flag is set, whose error-type bit is clear and whose completion flag is clear is reported as an error event.
- R4: A channel whose error flag and completion flag are both set and whose error-type bit is clear is reported only as a completion event (evt_is_err_o = 0), never as an error.
- R5: Events are presented from a pending word with error events at bit NCH+c and completion events at bit c. The highest set bit goes first, so all errors come before any completion, each group in descending channel order.
- R6: evt_chan_o is the pending bit index modulo NCH. evt_is_err_o is 1 exactly when the index is NCH or above.
- R7: In the cycle after a snapshot strobe taken in S_IDLE, done_clr_o equals the captured completion vector and err_clr_o equals the OR of the captured error and error-type vectors. In every other cycle both are zero.
- R8: While evt_valid_o is high and evt_ready_i is low, the presented event holds. An accepted event (valid and ready both high) removes that event, and the next cycle presents the next highest pending event.
- R9: evt_valid_o is high from the cycle after a snapshot that found events until the last event is accepted, and is low in the cycle after that. A snapshot with no events leaves evt_valid_o low.
- R10: In the cycle after an error event for channel c is accepted, chan_rst_o is one-hot at bit c. It is zero in every other cycle, including after an accepted completion.
- R11: A snapshot strobe raised while events are still being presented has no effect: no clear pulse is issued and the event sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snap_i | input | 1 | Snapshot strobe |
| done_vec_i | input | NCH | Per-channel completion flags |
| errflag_vec_i | input | NCH | Per-channel error flags |
| errtype_vec_i | input | NCH | Per-channel error type (1 = bus error) |
| evt_valid_o | output | 1 | An event is presented |
| evt_ready_i | input | 1 | Consumer accepts the presented event |
| evt_chan_o | output | $clog2(NCH) | Channel of the presented event |
| evt_is_err_o | output | 1 | Presented event is an error (1) or completion (0) |
| done_clr_o | output | NCH | One-cycle clear pulses for captured completion flags |
| err_clr_o | output | NCH | One-cycle clear pulses for captured error and type flags |
| chan_rst_o | output | NCH | One-cycle soft-reset request per channel |

## Verification
The assertions check the following on every cycle:
- a held event stays stable while the consumer is not ready;
- no completion is presented while an error is still pending;
- the reset request is one-hot and only follows an accepted error;
- clear pulses only follow a snapshot taken in S_IDLE;
- the valid signal drops after the last event is accepted.

The classification of each flag combination, including a termination together with completion counting as success, can only be shown by the bench's scenarios. The same holds for the exact descending order across both groups and for the claim that a snapshot during service leaves the sequence untouched. The bench compares each of these against a pending-word model it builds from the raw vectors.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_SERVE = 1'b1
    } evt_state_e;
endpackage

// File: rtl/dma_evt_classify.sv
module dma_evt_classify #(
    parameter int NCH = 16
) (
    input  logic [NCH-1:0] done_i,
    input  logic [NCH-1:0] eflag_i,
    input  logic [NCH-1:0] etype_i,
    output logic [NCH-1:0] real_err_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic bus_err;
        logic term_err;
        // both flags set: bus fault
        assign bus_err  = eflag_i[c] & etype_i[c];
        // termination only counts when no completion came with it
        assign term_err = eflag_i[c] & ~etype_i[c] & ~done_i[c];
        assign real_err_o[c] = bus_err | term_err;
    end
endmodule

// File: rtl/dma_evt_prio.sv
module dma_evt_prio #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o = |vec_i;
endmodule

// File: rtl/dma_evt_combiner.sv
module dma_evt_combiner
    import dma_evt_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           snap_i,
    input  logic [NCH-1:0] done_vec_i,
    input  logic [NCH-1:0] errflag_vec_i,
    input  logic [NCH-1:0] errtype_vec_i,
    output logic           evt_valid_o,
    input  logic           evt_ready_i,
    output logic [CW-1:0]  evt_chan_o,
    output logic           evt_is_err_o,
    output logic [NCH-1:0] done_clr_o,
    output logic [NCH-1:0] err_clr_o,
    output logic [NCH-1:0] chan_rst_o
);
    localparam int PW  = 2 * NCH;
    localparam int PIW = $clog2(PW);

    evt_state_e     state_q, state_d;
    logic [PW-1:0]  pend_q, pend_d;
    logic [NCH-1:0] real_err;
    logic [PIW-1:0] top_idx;
    logic           top_any;
    logic           accept;
    logic           take_snap;
    logic [PW-1:0]  top_mask;

    dma_evt_classify #(.NCH(NCH)) u_cls (
        .done_i     (done_vec_i),
        .eflag_i    (errflag_vec_i),
        .etype_i    (errtype_vec_i),
        .real_err_o (real_err)
    );

    dma_evt_prio #(.W(PW), .IW(PIW)) u_prio (
        .vec_i (pend_q),
        .idx_o (top_idx),
        .any_o (top_any)
    );

    assign evt_valid_o  = (state_q == S_SERVE);
    assign evt_is_err_o = (int'(top_idx) >= NCH);
    assign evt_chan_o   = evt_is_err_o ? CW'(int'(top_idx) - NCH) : CW'(top_idx);
    assign accept       = evt_valid_o & evt_ready_i;
    assign take_snap    = (state_q == S_IDLE) & snap_i;
    assign top_mask     = PW'(1) << top_idx;

    // next state and pending word
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            S_IDLE: begin
                if (snap_i) begin
                    pend_d = {real_err, done_vec_i};
                    if (|pend_d) begin
                        state_d = S_SERVE;      // SNAP_HIT
                    end                          // else SNAP_EMPTY
                end
            end
            S_SERVE: begin
                if (evt_ready_i) begin
                    pend_d = pend_q & ~top_mask;
                    if (pend_d == '0) begin
                        state_d = S_IDLE;       // SERVE_LAST
                    end                          // else SERVE_NEXT
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // registered output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_clr_o <= '0;
            err_clr_o  <= '0;
            chan_rst_o <= '0;
        end else begin
            done_clr_o <= take_snap ? done_vec_i : '0;
            err_clr_o  <= take_snap ? (errflag_vec_i | errtype_vec_i) : '0;
            chan_rst_o <= (accept && evt_is_err_o) ? (NCH'(1) << evt_chan_o) : '0;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o && !evt_ready_i |=> evt_valid_o && $stable(evt_chan_o) && $stable(evt_is_err_o)); // R8

    AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o && !evt_is_err_o |-> pend_q[PW-1:NCH] == '0); // R5

    AST_VALID_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> top_any); // R9

    AST_LAST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        accept && $countones(pend_q) == 1 |=> !evt_valid_o); // R9

    AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_rst_o)); // R10

    AST_RST_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        |chan_rst_o |-> $past(accept && evt_is_err_o)); // R10

    AST_CLR_AFTER_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_clr_o || |err_clr_o) |-> $past(snap_i && state_q == S_IDLE)); // R7

    AST_NO_CLR_IN_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o && snap_i |=> done_clr_o == '0 && err_clr_o == '0); // R11
endmodule

// File: tb/sim_dma_evt_combiner.sv
module sim_dma_evt_combiner;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snap = 1'b0;
    logic [15:0] done_v = '0, ef_v = '0, et_v = '0;
    logic        ready = 1'b0;
    logic        valid, is_err;
    logic [3:0]  chan;
    logic [15:0] done_clr, err_clr, chan_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_evt_combiner #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .snap_i(snap),
        .done_vec_i(done_v), .errflag_vec_i(ef_v), .errtype_vec_i(et_v),
        .evt_valid_o(valid), .evt_ready_i(ready),
        .evt_chan_o(chan), .evt_is_err_o(is_err),
        .done_clr_o(done_clr), .err_clr_o(err_clr), .chan_rst_o(chan_rst)
    );

    function automatic logic [31:0] exp_pend(logic [15:0] d, logic [15:0] ef, logic [15:0] et);
        logic [15:0] e;
        e = (ef & et) | (ef & ~et & ~d);
        return {e, d};
    endfunction

    function automatic int top_bit(logic [31:0] v);
        int r = -1;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic burst(input logic [15:0] d, input logic [15:0] ef, input logic [15:0] et,
                         input int rdy_pct, input bit inj, input string tag);
        logic [31:0] model;
        int guard;
        model = exp_pend(d, ef, et);
        done_v = d; ef_v = ef; et_v = et; snap = 1'b1;
        @(negedge clk);
        snap = 1'b0; done_v = '0; ef_v = '0; et_v = '0;
        check(done_clr == d, "R7", "done_clr", 32'(done_clr), 32'(d));
        check(err_clr == (ef | et), "R7", "err_clr", 32'(err_clr), 32'(ef | et));
        guard = 0;
        while (model != 0 && guard < 400) begin
            int  ei;
            bit  acc;
            logic [15:0] exp_rst;
            guard++;
            ei = top_bit(model);
            check(valid == 1'b1, "R9", "valid while pending", 32'(valid), 32'd1);
            check(int'(chan) == ei % 16, tag, "chan", 32'(chan), 32'(ei % 16));
            check(is_err == (ei >= 16), tag, "is_err", 32'(is_err), 32'(ei >= 16));
            acc = (int'($urandom % 100) < rdy_pct);
            ready = acc;
            if (inj) begin
                snap = 1'b1;
                done_v = 16'($urandom); ef_v = 16'($urandom); et_v = 16'($urandom);
            end
            @(negedge clk);
            ready = 1'b0; snap = 1'b0; done_v = '0; ef_v = '0; et_v = '0;
            if (inj) begin
                check(done_clr == '0 && err_clr == '0, "R11", "clear during service",
                      {done_clr, err_clr}, 32'd0);
            end
            exp_rst = (acc && ei >= 16) ? (16'd1 << (ei - 16)) : 16'd0;
            check(chan_rst == exp_rst, "R10", "chan_rst", 32'(chan_rst), 32'(exp_rst));
            if (acc) model[ei] = 1'b0;
        end
        check(valid == 1'b0, "R9", "valid after drain", 32'(valid), 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0407));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid == 1'b0, "R1", "valid", 32'(valid), 32'd0);
        check(done_clr == '0 && err_clr == '0 && chan_rst == '0, "R1", "pulses",
              {done_clr, err_clr}, 32'd0);

        // R2: bus error on channel 5 (also completed)
        burst(16'h0020, 16'h0020, 16'h0020, 100, 1'b0, "R2");
        // R3: termination without completion on channel 9
        burst(16'h0000, 16'h0200, 16'h0000, 100, 1'b0, "R3");
        // R4: termination with completion on channel 3 counts as success
        done_v = 16'h0008; ef_v = 16'h0008; et_v = '0; snap = 1'b1;
        @(negedge clk);
        snap = 1'b0; done_v = '0; ef_v = '0;
        check(valid && !is_err && chan == 4'd3, "R4", "success event",
              {valid, is_err, chan}, {1'b1, 1'b0, 4'd3});
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        check(chan_rst == '0, "R4", "no reset request", 32'(chan_rst), 32'd0);
        check(!valid, "R4", "single event only", 32'(valid), 32'd0);
        // empty snapshot
        burst(16'h0000, 16'h0000, 16'h0000, 100, 1'b0, "R9");
        // R5 and R6 ordering across both groups, ends and slow consumer
        burst(16'h8001, 16'h8001, 16'h8000, 30, 1'b0, "R5");
        burst(16'hffff, 16'hffff, 16'haaaa, 50, 1'b0, "R6");
        // R11: snapshots during service are ignored
        burst(16'h1234, 16'h0f0f, 16'h00ff, 40, 1'b1, "R11");

        for (int k = 0; k < 40; k++) begin
            burst(16'($urandom), 16'($urandom), 16'($urandom),
                  20 + int'($urandom % 81), bit'(k % 2), "R8");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule